// File: doc/BRIEF.md
# Accelerator Operation Controller

This block is the host-facing sequencer of a programmable arithmetic accelerator. The host writes 32-bit words into a command port, a control port and an error-clear port. Each write lasts one cycle. The controller decodes a sparse 8-bit command code and starts one of three operations: program execution, a data-memory wipe or an instruction-memory wipe. It drives the execution core and the wipe engines through one-cycle start pulses, and it waits for their done strobes. While it works, it publishes an 8-bit status code.

After reset, and after every program run, the controller wipes internal state before it returns to idle. A done interrupt pulse marks the end of every host-started operation. Error flags from the core are gathered into a sticky 32-bit error word. A fatal source, a lifecycle escalation or an illegal value in the sparse state register puts the controller into a locked state. The locked state can only be left by a reset, and while locked the controller keeps a frozen record of the fatal cause.

Top module: `acc_opctl`

## Requirements
- R1: During reset and in the first cycle after it, status is 0x04 and `state_wipe_start_o` is high. The start pulse lasts that one cycle. A later `wipe_done_i` moves status to 0x00 and raises no done interrupt.
- R2: An idle controller decodes bits 7:0 of a command write and ignores bits 31:8. On the next cycle, code 0xD8 gives status 0x01 and an `exec_start_o` pulse, 0xC3 gives status 0x02 and a `dmem_wipe_start_o` pulse, and 0x1E gives status 0x03 and an `imem_wipe_start_o` pulse. Each pulse lasts one cycle.
- R3: A command write with any other low-byte code leaves status at 0x00 and raises no start pulse.
- R4: A command write made while status is not 0x00 has no effect.
- R5: `exec_done_i` during execution gives status 0x04 and a `state_wipe_start_o` pulse on the next cycle. The `wipe_done_i` that follows gives status 0x00 with `done_irq_o` high for exactly one cycle.
- R6: `wipe_done_i` during a memory wipe gives status 0x00 with `done_irq_o` high for exactly one cycle.
- R7: The error word keeps its flags until the host clears them. `exec_sw_err_i`, sampled with `exec_done_i`, sets bits 5:0. `exec_rec_err_i`, sampled with `exec_done_i`, sets bits 7:6. Fatal causes set bits 23:16, with bit 20 for an illegal state, bit 22 for escalation and bit 23 for a fatal software error.
- R8: An error-clear write zeroes the error word when status is 0x00 or 0xFF. The write has no effect while an operation runs.
- R9: A control write sets `sw_errs_fatal_o` from bit 0 only while idle. When that bit is set, a nonzero `exec_sw_err_i` at `exec_done_i` counts as a fatal software error.
- R10: Any nonzero `fatal_err_i`, an `escalate_i`, or a fatal software error gives status 0xFF on the next cycle. The cause goes into `fatal_cause_o`, whose bit k mirrors error-word bit 16+k. Status and cause then stay fixed until reset, and commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_wdata_i | input | 32 | Command write data, code in bits 7:0 |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 32 | Control write data, bit 0 makes software errors fatal |
| errs_we_i | input | 1 | Error-word clear strobe |
| escalate_i | input | 1 | Lifecycle escalation request |
| fatal_err_i | input | 8 | Fatal error sources, bit k maps to error bit 16+k |
| exec_start_o | output | 1 | Start pulse to the execution core |
| exec_done_i | input | 1 | Execution core finished |
| exec_sw_err_i | input | 6 | Software error flags valid with exec_done_i |
| exec_rec_err_i | input | 2 | Recoverable error flags valid with exec_done_i |
| dmem_wipe_start_o | output | 1 | Start pulse for the data-memory wipe |
| imem_wipe_start_o | output | 1 | Start pulse for the instruction-memory wipe |
| state_wipe_start_o | output | 1 | Start pulse for the internal-state wipe |
| wipe_done_i | input | 1 | Active wipe engine finished |
| status_o | output | 8 | Status code |
| done_irq_o | output | 1 | Operation-complete interrupt pulse |
| sw_errs_fatal_o | output | 1 | Control bit readback |
| err_bits_o | output | 32 | Sticky error word |
| fatal_cause_o | output | 8 | Fatal cause, frozen once locked |

## Verification
The assertions check four rules on every cycle:
- the locked state never changes and the fatal cause is never updated while locked;
- at most one start pulse is high at a time, and an interrupt only appears together with idle status;
- a command written during execution does not move the state, and a control value never changes outside idle;
- an accepted clear empties the error word.

The bench scenarios cover the rest:
- the mapping from each of the 256 codes to a status value and a start pulse;
- the full operation sequences with their interrupt timing;
- the bit positions in the error word and the cause register;
- how the control bit turns a software error into a lock.

// File: rtl/acc_opctl_pkg.sv
package acc_opctl_pkg;

  parameter int unsigned CODE_W   = 8;
  parameter int unsigned STATUS_W = 8;
  parameter int unsigned FATAL_W  = 8;

  // Sparse state codes, pairwise Hamming distance of at least 3.
  typedef enum logic [5:0] {
    ST_IDLE    = 6'b000111,
    ST_EXEC    = 6'b011001,
    ST_DWIPE   = 6'b101010,
    ST_IWIPE   = 6'b110100,
    ST_INTWIPE = 6'b111111,
    ST_LOCKED  = 6'b100001
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_EXEC  = 2'd0,
    OP_DWIPE = 2'd1,
    OP_IWIPE = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  // Start pulse vector positions.
  localparam int unsigned SP_EXEC  = 0;
  localparam int unsigned SP_DWIPE = 1;
  localparam int unsigned SP_IWIPE = 2;
  localparam int unsigned SP_INT   = 3;
  localparam int unsigned SP_W     = 4;

  localparam logic [CODE_W-1:0] CMD_RUN    = 8'hD8;
  localparam logic [CODE_W-1:0] CMD_WIPE_D = 8'hC3;
  localparam logic [CODE_W-1:0] CMD_WIPE_I = 8'h1E;

  // Fatal cause positions used internally.
  localparam int unsigned FB_BAD_STATE = 4;
  localparam int unsigned FB_ESCALATE  = 6;
  localparam int unsigned FB_SW_FATAL  = 7;

  function automatic op_e decode_cmd(input logic [CODE_W-1:0] code);
    case (code)
      CMD_RUN:    return OP_EXEC;
      CMD_WIPE_D: return OP_DWIPE;
      CMD_WIPE_I: return OP_IWIPE;
      default:    return OP_NONE;
    endcase
  endfunction

  function automatic logic [STATUS_W-1:0] status_of(input seq_state_e s);
    case (s)
      ST_IDLE:    return 8'h00;
      ST_EXEC:    return 8'h01;
      ST_DWIPE:   return 8'h02;
      ST_IWIPE:   return 8'h03;
      ST_INTWIPE: return 8'h04;
      default:    return 8'hFF;
    endcase
  endfunction

  function automatic logic state_legal(input seq_state_e s);
    return (s == ST_IDLE) || (s == ST_EXEC) || (s == ST_DWIPE) ||
           (s == ST_IWIPE) || (s == ST_INTWIPE) || (s == ST_LOCKED);
  endfunction

  function automatic logic [FATAL_W-1:0] fatal_merge(
      input logic [FATAL_W-1:0] ext, input logic esc,
      input logic bad, input logic swf);
    logic [FATAL_W-1:0] v;
    v = ext;
    v[FB_ESCALATE]  = v[FB_ESCALATE] | esc;
    v[FB_BAD_STATE] = v[FB_BAD_STATE] | bad;
    v[FB_SW_FATAL]  = v[FB_SW_FATAL] | swf;
    return v;
  endfunction

endpackage

// File: rtl/acc_cmd_dec.sv
module acc_cmd_dec
  import acc_opctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] wdata_i,
  output logic              valid_o,
  output op_e               op_o
);

  always_comb begin
    op_o    = decode_cmd(wdata_i[CODE_W-1:0]);
    valid_o = (op_o != OP_NONE);
  end

endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_opctl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_we_i,
  input  logic            cmd_valid_i,
  input  op_e             cmd_op_i,
  input  logic            exec_done_i,
  input  logic            wipe_done_i,
  input  logic            fatal_any_i,
  output seq_state_e      state_o,
  output logic [SP_W-1:0] start_o,
  output logic            irq_o,
  output logic            idle_o,
  output logic            locked_o,
  output logic            bad_state_o
);

  seq_state_e      state_q, state_d;
  logic [SP_W-1:0] start_q, start_d;
  logic            irq_q, irq_d;
  logic            op_q, op_d;

  always_comb begin
    state_d = state_q;
    start_d = '0;
    irq_d   = 1'b0;
    op_d    = op_q;
    if (fatal_any_i) begin
      state_d = ST_LOCKED;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cmd_we_i && cmd_valid_i) begin
            op_d = 1'b1;
            case (cmd_op_i)
              OP_EXEC:  begin state_d = ST_EXEC;  start_d[SP_EXEC]  = 1'b1; end
              OP_DWIPE: begin state_d = ST_DWIPE; start_d[SP_DWIPE] = 1'b1; end
              default:  begin state_d = ST_IWIPE; start_d[SP_IWIPE] = 1'b1; end
            endcase
          end
        end
        ST_EXEC: begin
          if (exec_done_i) begin
            state_d         = ST_INTWIPE;
            start_d[SP_INT] = 1'b1;
          end
        end
        ST_DWIPE, ST_IWIPE, ST_INTWIPE: begin
          if (wipe_done_i) begin
            state_d = ST_IDLE;
            irq_d   = op_q;
            op_d    = 1'b0;
          end
        end
        ST_LOCKED: state_d = ST_LOCKED;
        default:   state_d = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INTWIPE;
      start_q <= SP_W'(1) << SP_INT;
      irq_q   <= 1'b0;
      op_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      irq_q   <= irq_d;
      op_q    <= op_d;
    end
  end

  assign state_o     = state_q;
  assign start_o     = start_q;
  assign irq_o       = irq_q;
  assign idle_o      = (state_q == ST_IDLE);
  assign locked_o    = (state_q == ST_LOCKED);
  assign bad_state_o = !state_legal(state_q);

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o); // R10
  AST_START_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_q)); // R2
  AST_IRQ_AT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> idle_o); // R5
  AST_BUSY_CMD_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && state_q == ST_EXEC && !exec_done_i && !fatal_any_i)
      |=> (state_q == ST_EXEC)); // R4

endmodule

// File: rtl/acc_err_bank.sv
module acc_err_bank #(
  parameter int unsigned SW_W    = 6,
  parameter int unsigned REC_W   = 2,
  parameter int unsigned FAT_W   = 8,
  parameter int unsigned FAT_LSB = 16,
  parameter int unsigned REG_W   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             rep_i,
  input  logic [SW_W-1:0]  sw_i,
  input  logic [REC_W-1:0] rec_i,
  input  logic [FAT_W-1:0] fatal_i,
  input  logic             locked_i,
  output logic [REG_W-1:0] err_o,
  output logic [FAT_W-1:0] cause_o
);

  localparam int unsigned REC_LSB = SW_W;

  logic [REG_W-1:0] err_q, new_bits;
  logic [FAT_W-1:0] cause_q;

  always_comb begin
    new_bits = '0;
    if (rep_i) begin
      new_bits[SW_W-1:0]        = sw_i;
      new_bits[REC_LSB+:REC_W]  = rec_i;
    end
    new_bits[FAT_LSB+:FAT_W] = fatal_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= '0;
      cause_q <= '0;
    end else begin
      err_q <= (clr_i ? '0 : err_q) | new_bits;
      if (!locked_i && (|fatal_i)) cause_q <= fatal_i;
    end
  end

  assign err_o   = err_q;
  assign cause_o = cause_q;

  AST_CAUSE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |=> $stable(cause_q)); // R10
  AST_ERR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !rep_i && fatal_i == '0) |=> (err_q == '0)); // R8

endmodule

// File: rtl/acc_opctl.sv
module acc_opctl
  import acc_opctl_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SW_ERR_W  = 6,
  parameter int unsigned REC_ERR_W = 2,
  parameter int unsigned FATAL_LSB = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_we_i,
  input  logic [DATA_W-1:0]    cmd_wdata_i,
  input  logic                 ctrl_we_i,
  input  logic [DATA_W-1:0]    ctrl_wdata_i,
  input  logic                 errs_we_i,
  input  logic                 escalate_i,
  input  logic [FATAL_W-1:0]   fatal_err_i,
  output logic                 exec_start_o,
  input  logic                 exec_done_i,
  input  logic [SW_ERR_W-1:0]  exec_sw_err_i,
  input  logic [REC_ERR_W-1:0] exec_rec_err_i,
  output logic                 dmem_wipe_start_o,
  output logic                 imem_wipe_start_o,
  output logic                 state_wipe_start_o,
  input  logic                 wipe_done_i,
  output logic [STATUS_W-1:0]  status_o,
  output logic                 done_irq_o,
  output logic                 sw_errs_fatal_o,
  output logic [DATA_W-1:0]    err_bits_o,
  output logic [FATAL_W-1:0]   fatal_cause_o
);

  logic            cmd_valid;
  op_e             cmd_op;
  seq_state_e      state;
  logic [SP_W-1:0] start;
  logic            idle, locked, bad_state;
  logic            ctrl_q;
  logic            exec_report, sw_fatal_evt, fatal_any, err_clr;
  logic [FATAL_W-1:0] fatal_vec;

  acc_cmd_dec #(.DATA_W(DATA_W)) u_dec (
    .wdata_i (cmd_wdata_i),
    .valid_o (cmd_valid),
    .op_o    (cmd_op)
  );

  // Named events for the error bank and assertions.
  assign exec_report  = exec_done_i && (state == ST_EXEC);
  assign sw_fatal_evt = exec_report && ctrl_q && (|exec_sw_err_i);
  assign fatal_vec    = fatal_merge(fatal_err_i, escalate_i, bad_state, sw_fatal_evt);
  assign fatal_any    = |fatal_vec;
  assign err_clr      = errs_we_i && (idle || locked);

  acc_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_we_i    (cmd_we_i),
    .cmd_valid_i (cmd_valid),
    .cmd_op_i    (cmd_op),
    .exec_done_i (exec_done_i),
    .wipe_done_i (wipe_done_i),
    .fatal_any_i (fatal_any),
    .state_o     (state),
    .start_o     (start),
    .irq_o       (done_irq_o),
    .idle_o      (idle),
    .locked_o    (locked),
    .bad_state_o (bad_state)
  );

  acc_err_bank #(
    .SW_W    (SW_ERR_W),
    .REC_W   (REC_ERR_W),
    .FAT_W   (FATAL_W),
    .FAT_LSB (FATAL_LSB),
    .REG_W   (DATA_W)
  ) u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (err_clr),
    .rep_i    (exec_report),
    .sw_i     (exec_sw_err_i),
    .rec_i    (exec_rec_err_i),
    .fatal_i  (fatal_vec),
    .locked_i (locked),
    .err_o    (err_bits_o),
    .cause_o  (fatal_cause_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ctrl_q <= 1'b0;
    else if (ctrl_we_i && idle) ctrl_q <= ctrl_wdata_i[0];
  end

  assign sw_errs_fatal_o    = ctrl_q;
  assign status_o           = status_of(state);
  assign exec_start_o       = start[SP_EXEC];
  assign dmem_wipe_start_o  = start[SP_DWIPE];
  assign imem_wipe_start_o  = start[SP_IWIPE];
  assign state_wipe_start_o = start[SP_INT];

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle |=> $stable(ctrl_q)); // R9

endmodule

// File: tb/tb_acc_opctl.sv
module tb_acc_opctl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 0, ctrl_we = 0, errs_we = 0, esc = 0;
  logic [31:0] cmd_wd = 0, ctrl_wd = 0;
  logic [7:0]  fat = 0;
  logic        exec_done = 0, wipe_done = 0;
  logic [5:0]  sw_err = 0;
  logic [1:0]  rec_err = 0;
  logic        exec_start, dwipe_start, iwipe_start, swipe_start, irq, swf;
  logic [7:0]  status, cause;
  logic [31:0] errs;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  acc_opctl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wd),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .errs_we_i(errs_we), .escalate_i(esc), .fatal_err_i(fat),
    .exec_start_o(exec_start), .exec_done_i(exec_done),
    .exec_sw_err_i(sw_err), .exec_rec_err_i(rec_err),
    .dmem_wipe_start_o(dwipe_start), .imem_wipe_start_o(iwipe_start),
    .state_wipe_start_o(swipe_start), .wipe_done_i(wipe_done),
    .status_o(status), .done_irq_o(irq), .sw_errs_fatal_o(swf),
    .err_bits_o(errs), .fatal_cause_o(cause)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] starts();
    return {swipe_start, iwipe_start, dwipe_start, exec_start};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R1 status after reset", {24'h0, status}, 32'h04);
    check("R1 state wipe start", {28'h0, starts()}, 32'h8);
    tick();
    check("R1 start pulse ends", {28'h0, starts()}, 32'h0);
    wipe_done = 1; tick(); wipe_done = 0;
    check("R1 idle no irq", {23'h0, irq, status}, 32'h0);
  endtask

  task automatic command(input logic [7:0] code, input logic [23:0] hi);
    cmd_we = 1; cmd_wd = {hi, code}; tick(); cmd_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    do_reset();

    // R3: exhaustive sweep of unknown codes
    for (int c = 0; c < 256; c++) begin
      if (c != 8'hD8 && c != 8'hC3 && c != 8'h1E) begin
        command(8'(c), 24'hA5C3D8);
        check($sformatf("R3 code %02h", c), {20'h0, starts(), status}, 32'h0);
      end
    end

    // R2 / R6: memory wipes with upper bits set
    command(8'hC3, 24'hFFFFFF);
    check("R2 dmem wipe", {20'h0, starts(), status}, 32'h0000_0202);
    tick();
    check("R2 dmem pulse ends", {28'h0, starts()}, 32'h0);
    wipe_done = 1; tick(); wipe_done = 0;
    check("R6 dmem done irq", {23'h0, irq, status}, 32'h100);
    tick();
    check("R6 irq one cycle", {31'h0, irq}, 32'h0);

    command(8'h1E, 24'h123456);
    check("R2 imem wipe", {20'h0, starts(), status}, 32'h0000_0403);
    // R4: command while busy dropped
    command(8'hD8, 24'h0);
    check("R4 busy cmd dropped", {20'h0, starts(), status}, 32'h03);
    wipe_done = 1; tick(); wipe_done = 0;
    check("R6 imem done irq", {23'h0, irq, status}, 32'h100);

    // R2 / R5 / R7: execute with errors
    command(8'hD8, 24'h00FF00);
    check("R2 exec start", {20'h0, starts(), status}, 32'h0000_0101);
    ctrl_we = 1; ctrl_wd = 32'h1; errs_we = 1; tick(); ctrl_we = 0; errs_we = 0;
    check("R9 ctrl write busy dropped", {31'h0, swf}, 32'h0);
    sw_err = 6'b000101; rec_err = 2'b10; exec_done = 1; tick();
    exec_done = 0; sw_err = 0; rec_err = 0;
    check("R5 exec done wipe", {20'h0, starts(), status}, 32'h0000_0804);
    check("R7 err layout", errs, 32'h0000_0085);
    errs_we = 1; tick(); errs_we = 0;
    check("R8 clear while busy dropped", errs, 32'h0000_0085);
    wipe_done = 1; tick(); wipe_done = 0;
    check("R5 exec ends irq", {23'h0, irq, status}, 32'h100);
    tick();
    check("R5 irq one cycle", {31'h0, irq}, 32'h0);
    errs_we = 1; tick(); errs_we = 0;
    check("R8 clear in idle", errs, 32'h0);

    // R9: software errors fatal
    ctrl_we = 1; ctrl_wd = 32'hFFFF_FFF1; tick(); ctrl_we = 0;
    check("R9 ctrl set", {31'h0, swf}, 32'h1);
    command(8'hD8, 24'h0);
    sw_err = 6'b001000; exec_done = 1; tick(); exec_done = 0; sw_err = 0;
    check("R9 sw fatal lock", {24'h0, status}, 32'hFF);
    check("R7 sw fatal bits", errs, 32'h0080_0008);
    check("R10 cause sw", {24'h0, cause}, 32'h80);

    // R10: external fatal, frozen cause
    do_reset();
    check("R9 ctrl reset", {31'h0, swf}, 32'h0);
    command(8'hD8, 24'h0);
    fat = 8'h05; tick(); fat = 0;
    check("R10 fatal lock", {24'h0, status}, 32'hFF);
    check("R10 fatal cause", {24'h0, cause}, 32'h05);
    check("R7 fatal bits", errs, 32'h0005_0000);
    esc = 1; tick(); esc = 0;
    check("R10 cause frozen", {24'h0, cause}, 32'h05);
    check("R7 escalation bit", errs, 32'h0045_0000);
    command(8'hC3, 24'h0);
    check("R10 cmd ignored locked", {20'h0, starts(), status}, 32'hFF);
    errs_we = 1; tick(); errs_we = 0;
    check("R8 clear while locked", errs, 32'h0);
    check("R10 cause after clear", {24'h0, cause}, 32'h05);
    repeat (5) tick();
    check("R10 stays locked", {24'h0, status}, 32'hFF);

    // R10: escalation in idle
    do_reset();
    esc = 1; tick(); esc = 0;
    check("R10 escalate lock", {16'h0, cause, status}, 32'h40FF);
    check("R7 escalate err", errs, 32'h0040_0000);

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule